// File: doc/BRIEF.md
# Selectable Single-Sum Checksum Unit

This unit folds a stream of fixed-width data chunks into one check value of the same width. A stream starts with a clear, which zeroes the running value and latches which of three combining rules applies: column-wise XOR (longitudinal parity), two's complement addition with the top carry dropped, or one's complement addition with the top carry wrapped back into bit 0. Each accepted chunk updates the running value in one clock.

The chunk flagged as last ends the stream. One clock later the unit pulses a done flag, and the running value on its output is the final check value. A received check value presented alongside the last chunk is compared with that final value, and the result appears with the done pulse. The sender uses the value; the receiver uses the match flag. Chunk width is a parameter and may be 8, 16 or 32 bits.

Top module: `chk_accum_top`

## Requirements
- R1: After reset, and one clock after any cycle with `clear_i` high, `sum_o` is zero and `done_o` and `match_o` are low.
- R2: With mode code 2'b00 (code 2'b11 acts the same), each bit of `sum_o` is the XOR of that bit across all chunks accepted since the clear. Columns do not interact.
- R3: With mode code 2'b01, `sum_o` is the sum of the accepted chunks modulo 2 to the power W. Carries move between columns, and a carry out of bit W-1 is discarded.
- R4: With mode code 2'b10, every add that carries out of bit W-1 adds that carry into bit 0 in the same clock. For example, with W=16, 0xFFFF plus 0x0001 gives 0x0001, and 0x8000 plus 0x8000 gives 0x0001.
- R5: `mode_i` is sampled only in a cycle with `clear_i` high. A change of `mode_i` in any other cycle does not affect the running stream.
- R6: `done_o` is high for exactly one clock, in the clock after a chunk with `last_i` high is accepted. At that point `sum_o` holds the final value.
- R7: `match_o` is high only together with `done_o`. It is high when the final value equals `check_i` as sampled with the last chunk.
- R8: In a cycle with both `valid_i` and `clear_i` low, `sum_o` keeps its value.
- R9: When `clear_i` and `valid_i` are high together, the clear wins and that chunk is discarded.
- R10: In XOR mode, flipping the same bit position in two chunks of a stream leaves the check value unchanged, so `match_o` stays high. Flipping a single bit always makes `match_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Start a new stream: zero the value and latch the mode |
| mode_i | input | 2 | Combining rule: 00 XOR, 01 add, 10 one's complement add, 11 XOR |
| valid_i | input | 1 | The chunk on `data_i` is accepted |
| data_i | input | W | Data chunk |
| last_i | input | 1 | The chunk is the last one of the stream |
| check_i | input | W | Received check value, sampled with the last chunk |
| sum_o | output | W | Running check value |
| done_o | output | 1 | One-clock pulse after the last chunk |
| match_o | output | 1 | The final value equals the received check value, valid with `done_o` |

## Verification
Every result of this unit is due one clock after the input that causes it. A chunk shows up in `sum_o`, a clear zeroes the value, and a last chunk raises `done_o` and `match_o`, each at the next rising edge. The bench drives each cycle just after an edge and advances its behavioural model for that same edge. It then compares all three outputs one time unit after the edge, so the expected value and the design's register update always refer to the same clock. Directed streams cover the carry cases, the mid-stream mode change, the clear-versus-chunk collision and the paired column flips. Pseudo-random streams exercise every mode in addition.

// File: rtl/chk_pkg.sv
package chk_pkg;
  typedef enum logic [1:0] {
    CHK_XOR = 2'b00,
    CHK_ADD = 2'b01,
    CHK_OC  = 2'b10,
    CHK_RSV = 2'b11
  } chk_mode_e;
endpackage

// File: rtl/chk_xor_lane.sv
module chk_xor_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_col
    assign y_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/chk_wrap_add.sv
// Adder with selectable carry handling: wrap = 1 folds the top carry into bit 0.
module chk_wrap_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         wrap_i,
  output logic [W-1:0] y_o
);
  localparam int SW = W + 1;
  logic [SW-1:0] raw;
  logic [W-1:0]  eac;

  assign raw = {1'b0, a_i} + {1'b0, b_i};
  // at most 2^(W+1)-2, so the second add cannot carry again
  assign eac = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  assign y_o = wrap_i ? eac : raw[W-1:0];
endmodule

// File: rtl/chk_combine.sv
module chk_combine
  import chk_pkg::*;
#(
  parameter int W = 16
) (
  input  chk_mode_e    mode_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] xor_w, add_w;

  chk_xor_lane #(.W(W)) u_xor (.a_i(acc_i), .b_i(data_i), .y_o(xor_w));
  chk_wrap_add #(.W(W)) u_add (
    .a_i(acc_i), .b_i(data_i), .wrap_i(mode_i == CHK_OC), .y_o(add_w)
  );

  always_comb begin
    unique case (mode_i)
      CHK_ADD, CHK_OC: res_o = add_w;
      default:         res_o = xor_w;
    endcase
  end
endmodule

// File: rtl/chk_accum_top.sv
module chk_accum_top
  import chk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic [1:0]   mode_i,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  input  logic         last_i,
  input  logic [W-1:0] check_i,
  output logic [W-1:0] sum_o,
  output logic         done_o,
  output logic         match_o
);
  chk_mode_e    mode_q;
  logic [W-1:0] acc_q, nxt_w;
  logic         done_q, match_q;

  chk_combine #(.W(W)) u_comb (
    .mode_i(mode_q), .acc_i(acc_q), .data_i(data_i), .res_o(nxt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mode_q  <= CHK_XOR;
      done_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
      if (clear_i) begin
        acc_q  <= '0;
        mode_q <= chk_mode_e'(mode_i);
      end else if (valid_i) begin
        acc_q <= nxt_w;
        if (last_i) begin
          done_q  <= 1'b1;
          match_q <= (nxt_w == check_i);
        end
      end
    end
  end

  assign sum_o   = acc_q;
  assign done_o  = done_q;
  assign match_o = match_q;
endmodule

// File: rtl/chk_accum_chk.sv
module chk_accum_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clear_i,
  input logic         valid_i,
  input logic         last_i,
  input logic [W-1:0] data_i,
  input logic [1:0]   mode_q_i,
  input logic [W-1:0] sum_o,
  input logic         done_o,
  input logic         match_o
);
  logic [W-1:0] add_ref;
  logic         take;
  assign add_ref = sum_o + data_i;
  assign take    = valid_i && !clear_i;

  assert_clear_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sum_o == '0) && !done_o && !match_o);

  assert_int_add_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode_q_i == 2'b01) |=> sum_o == $past(add_ref));

  assert_oc_zero_add_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode_q_i == 2'b10 && data_i == '0) |=> $stable(sum_o));

  assert_mode_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> $stable(mode_q_i));

  assert_done_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && last_i) |=> done_o);

  assert_done_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take && last_i) |=> !done_o);

  assert_match_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> done_o);

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !valid_i) |=> $stable(sum_o));

  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && valid_i) |=> sum_o == '0);
endmodule

bind chk_accum_top chk_accum_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .valid_i(valid_i),
  .last_i(last_i), .data_i(data_i), .mode_q_i(mode_q), .sum_o(sum_o),
  .done_o(done_o), .match_o(match_o)
);

// File: tb/chk_accum_top_tb_top.sv
`timescale 1ns/1ps
module chk_accum_top_tb_top;
  localparam int W = 16;
  localparam int WDOG = 100000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clear_i = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         last_i = 1'b0;
  logic [W-1:0] check_i = '0;
  logic [W-1:0] sum_o;
  logic         done_o, match_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // behavioural model state
  logic [1:0]   m_mode = 2'b00;
  logic [W-1:0] m_acc = '0;
  logic         m_done = 1'b0;
  logic         m_match = 1'b0;

  always #2 clk_i = ~clk_i;

  chk_accum_top #(.W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .mode_i(mode_i),
    .valid_i(valid_i), .data_i(data_i), .last_i(last_i), .check_i(check_i),
    .sum_o(sum_o), .done_o(done_o), .match_o(match_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [W-1:0] ref_comb(input logic [1:0] md,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    longint unsigned s;
    longint unsigned lim;
    lim = longint'(1) << W;
    if (md == 2'b01) return W'((longint'(a) + longint'(b)) % lim);
    if (md == 2'b10) begin
      s = longint'(a) + longint'(b);
      if (s >= lim) s = s - lim + 1;
      return W'(s);
    end
    return a ^ b;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string mode_req(input logic [1:0] md);
    if (md == 2'b01) return "R3";
    if (md == 2'b10) return "R4";
    return "R2";
  endfunction

  // one clock: drive, advance model for that edge, compare just after it
  task automatic step(input bit clr, input logic [1:0] md, input bit v,
                      input logic [W-1:0] d, input bit l, input logic [W-1:0] chk);
    logic [W-1:0] nx;
    clear_i = clr; mode_i = md; valid_i = v; data_i = d; last_i = l; check_i = chk;
    @(posedge clk_i);
    if (clr) begin
      m_acc = '0; m_mode = md; m_done = 1'b0; m_match = 1'b0;
    end else if (v) begin
      nx = ref_comb(m_mode, m_acc, d);
      m_acc = nx; m_done = l; m_match = l && (nx == chk);
    end else begin
      m_done = 1'b0; m_match = 1'b0;
    end
    #1;
    check(sum_o == m_acc, clr ? "R1 sum" : mode_req(m_mode), longint'(sum_o), longint'(m_acc));
    check(done_o == m_done, "R6 done", longint'(done_o), longint'(m_done));
    check(match_o == m_match, "R7 match", longint'(match_o), longint'(m_match));
  endtask

  task automatic idle();
    step(1'b0, mode_i, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    logic [W-1:0] lfsr;
    logic [W-1:0] good;
    logic [W-1:0] pkt [4];

    repeat (3) @(posedge clk_i);
    #1;
    check(sum_o == '0 && !done_o && !match_o, "R1 reset", longint'(sum_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R2 XOR stream with matching check
    step(1, 2'b00, 0, '0, 0, '0);
    step(0, 2'b00, 1, 16'h1234, 0, '0);
    step(0, 2'b00, 1, 16'h00FF, 0, '0);
    step(0, 2'b00, 1, 16'hA5A5, 1, 16'h1234 ^ 16'h00FF ^ 16'hA5A5);
    check(sum_o == 16'hB76E && match_o, "R2 xor value", longint'(sum_o), 16'hB76E);
    idle();
    check(!done_o && !match_o, "R6 single pulse", longint'(done_o), 0);

    // R3 integer add drops top carry, wrong check gives no match
    step(1, 2'b01, 0, '0, 0, '0);
    step(0, 2'b01, 1, 16'hFFFF, 0, '0);
    step(0, 2'b01, 1, 16'h0002, 1, 16'h0002);
    check(sum_o == 16'h0001, "R3 carry dropped", longint'(sum_o), 16'h0001);
    check(done_o && !match_o, "R7 mismatch", longint'(match_o), 0);

    // R4 end-around carry
    step(1, 2'b10, 0, '0, 0, '0);
    step(0, 2'b10, 1, 16'hFFFF, 0, '0);
    step(0, 2'b10, 1, 16'h0001, 0, '0);
    check(sum_o == 16'h0001, "R4 eac ffff+1", longint'(sum_o), 16'h0001);
    step(1, 2'b10, 0, '0, 0, '0);
    step(0, 2'b10, 1, 16'h8000, 0, '0);
    step(0, 2'b10, 1, 16'h8000, 1, 16'h0001);
    check(sum_o == 16'h0001 && match_o, "R4 eac 8000+8000", longint'(sum_o), 16'h0001);

    // R5 mode change mid-stream ignored
    step(1, 2'b01, 0, '0, 0, '0);
    step(0, 2'b01, 1, 16'h00F0, 0, '0);
    step(0, 2'b00, 1, 16'h00F0, 0, '0);
    check(sum_o == 16'h01E0, "R5 mode held", longint'(sum_o), 16'h01E0);

    // R8 idle holds
    idle(); idle();
    check(sum_o == 16'h01E0, "R8 hold", longint'(sum_o), 16'h01E0);

    // R9 clear beats valid
    step(1, 2'b01, 1, 16'h7777, 1, 16'h7777);
    check(sum_o == '0 && !done_o, "R9 clear wins", longint'(sum_o), 0);

    // R10 paired column flips undetected in XOR, single flip detected
    pkt[0] = 16'h3C5A; pkt[1] = 16'h1111; pkt[2] = 16'hF00F; pkt[3] = 16'h0BAD;
    good = pkt[0] ^ pkt[1] ^ pkt[2] ^ pkt[3];
    step(1, 2'b00, 0, '0, 0, '0);
    step(0, 2'b00, 1, pkt[0] ^ 16'h0008, 0, '0);
    step(0, 2'b00, 1, pkt[1], 0, '0);
    step(0, 2'b00, 1, pkt[2] ^ 16'h0008, 0, '0);
    step(0, 2'b00, 1, pkt[3], 1, good);
    check(match_o == 1'b1, "R10 double flip missed", longint'(match_o), 1);
    step(1, 2'b00, 0, '0, 0, '0);
    step(0, 2'b00, 1, pkt[0], 0, '0);
    step(0, 2'b00, 1, pkt[1] ^ 16'h0400, 0, '0);
    step(0, 2'b00, 1, pkt[2], 0, '0);
    step(0, 2'b00, 1, pkt[3], 1, good);
    check(done_o && !match_o, "R10 single flip caught", longint'(match_o), 0);

    // reserved code acts as XOR (R2)
    step(1, 2'b11, 0, '0, 0, '0);
    step(0, 2'b11, 1, 16'h0F0F, 0, '0);
    step(0, 2'b11, 1, 16'h0F0F, 0, '0);
    check(sum_o == '0, "R2 code 11", longint'(sum_o), 0);

    // pseudo-random streams in every mode, model compared each clock
    lfsr = 16'hACE1;
    for (int s = 0; s < 60; s++) begin
      logic [1:0] md;
      md = 2'(s % 4);
      step(1, md, 0, '0, 0, '0);
      for (int k = 0; k < 12; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[0] && lfsr[5]) idle();
        else step(0, ~md, 1, lfsr, k == 11, (k == 11 && lfsr[3]) ? m_acc : lfsr);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule